// File: doc/BRIEF.md
# Per-Consumer Two-Level Sharer Predictor

This block guesses which processors will read a memory block after its next write. For each history entry (chosen by a lookup index, for instance a hash of the writing instruction and the block address) it keeps, for every processor, a short shift register of that processor's presence in the last few sharer sets. That pattern selects a 2-bit up/down saturating counter from a bank private to the processor. The upper bit of the selected counter is the guess for that processor. All processor lanes are evaluated side by side in one cycle, so the result is an N-bit predicted consumer vector.

Training arrives on a separate update port carrying an entry index and the real sharer bitmap. For every processor the counter selected by that entry's current pattern moves toward the observed bit, and the observed bit is then shifted into the pattern. The counter banks are shared by all entries, while each entry keeps its own patterns. Moving the data and coherence actions are left to the surrounding logic.

Top module: `cons_predictor`

## Requirements
- R1: After a synchronous active-low reset every counter holds 1 (weakly not a consumer) and every history pattern is zero. A lookup of any entry then returns an all-zero vector. `pred_valid` and `pred_consumers` reset to 0.
- R2: `pred_valid` equals `lookup_valid` delayed by one clock. `pred_consumers` loads on a clock edge where `lookup_valid` is high and holds its value otherwise.
- R3: Bit p of `pred_consumers` is bit 1 (the upper bit) of processor p's counter, selected by p's pattern at the looked-up entry. Counter values 2 and 3 give 1; values 0 and 1 give 0.
- R4: On an update with sharer bit p high, p's selected counter increments and saturates at 3.
- R5: On an update with sharer bit p low, p's selected counter decrements and saturates at 0.
- R6: Each entry holds DEPTH history bits per processor. The newest presence bit enters at bit 0 and the oldest bit drops out of the top. The pattern value, read as an unsigned number, is the number of the counter it selects.
- R7: The lanes are independent. Processor p's counters and pattern change only through sharer bit p and p's own pattern.
- R8: Each processor has a single bank of 2^DEPTH counters, used by every entry. A counter trained through one entry is seen by lookups of another entry that holds the same pattern.
- R9: A lookup and an update on the same edge see the state from before that update.
- R10: An update changes only the counter selected by the pattern. Every other counter in the bank keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_valid | input | 1 | Request a prediction for `lookup_idx` |
| lookup_idx | input | $clog2(ENTRIES) | History entry to predict from |
| update_valid | input | 1 | Train with `update_sharers` at `update_idx` |
| update_idx | input | $clog2(ENTRIES) | History entry to train |
| update_sharers | input | NPROC | Actual sharer bitmap; bit p is processor p |
| pred_valid | output | 1 | `pred_consumers` holds a new prediction |
| pred_consumers | output | NPROC | Predicted consumer vector; bit p is processor p |

## Verification
A prediction is due exactly one clock after the lookup is presented. The bench drives every input on the falling edge and reads `pred_valid` and `pred_consumers` on the next falling edge, after the single register stage has loaded. An update becomes visible to lookups presented on the following cycle, while a lookup on the same edge as an update must still show the old state. The vector table puts lookups both beside their updates and one row after them to cover both timings. The expected vectors follow the counter and pattern arithmetic by hand, row by row.

// File: rtl/cpred_pkg.sv
`timescale 1ns/1ps
// Package: shared counter type and the saturating step used by every lane.
// Assumes a 2-bit counter whose upper bit is the consumer guess.
package cpred_pkg;
    localparam int CTR_W = 2;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_INIT = ctr_t'(1);
    localparam ctr_t CTR_TOP  = '1;
    localparam ctr_t CTR_BOT  = '0;

    // Move a counter one step toward the observed outcome, clamped at both ends.
    function automatic ctr_t ctr_step(ctr_t c, logic seen);
        if (seen)
            return (c == CTR_TOP) ? c : c + ctr_t'(1);
        else
            return (c == CTR_BOT) ? c : c - ctr_t'(1);
    endfunction
endpackage

// File: rtl/cpred_hist_table.sv
`timescale 1ns/1ps
// Module: per-entry presence history. Each entry holds one DEPTH-bit shift
// pattern per processor. The newest bit sits at bit 0 of the lane slice.
// Both the read ports are combinational. A write shifts in the observed
// sharer bits at the update entry on the clock edge.
// Assumes ENTRIES >= 2 and synchronous active-low reset.
module cpred_hist_table #(
    parameter int NPROC   = 4,
    parameter int DEPTH   = 2,
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [NPROC*DEPTH-1:0]     rd_pat,
    input  logic                       up_en,
    input  logic [$clog2(ENTRIES)-1:0] up_idx,
    input  logic [NPROC-1:0]           up_bits,
    output logic [NPROC*DEPTH-1:0]     up_pat
);
    localparam int ROW_W = NPROC * DEPTH;

    logic [ROW_W-1:0] hist_q [ENTRIES];
    logic [ROW_W-1:0] next_row;

    assign rd_pat = hist_q[rd_idx];
    assign up_pat = hist_q[up_idx];

    // Build the shifted row lane by lane; DEPTH picks the shift form.
    for (genvar p = 0; p < NPROC; p++) begin : g_shift
        if (DEPTH == 1) begin : g_one
            assign next_row[p] = up_bits[p];
        end else begin : g_many
            assign next_row[p*DEPTH +: DEPTH] = {up_pat[p*DEPTH +: DEPTH-1], up_bits[p]};

            // R6: older bits move up by one position
            assert_hist_age_R6: assert property (@(posedge clk) disable iff (!rst_n)
                up_en |=> hist_q[$past(up_idx)][p*DEPTH+1 +: DEPTH-1] == $past(up_pat[p*DEPTH +: DEPTH-1]));
        end

        // R6: the observed bit lands at the newest position
        assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
            up_en |=> hist_q[$past(up_idx)][p*DEPTH] == $past(up_bits[p]));
    end

    // Clear all patterns on reset, otherwise write the shifted row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++)
                hist_q[e] <= '0;
        end else if (up_en) begin
            hist_q[up_idx] <= next_row;
        end
    end
endmodule

// File: rtl/cpred_ctr_lane.sv
`timescale 1ns/1ps
// Module: one processor's bank of 2^DEPTH saturating counters. The read
// pattern picks the counter whose upper bit is the guess. The update
// pattern picks the counter to train.
// Assumes the patterns come from this processor's own history only.
module cpred_ctr_lane
    import cpred_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] rd_pat,
    output logic             rd_guess,
    input  logic             up_en,
    input  logic [DEPTH-1:0] up_pat,
    input  logic             up_seen
);
    localparam int SLOTS = 1 << DEPTH;

    ctr_t ctr_q [SLOTS];

    // Reset to weak-no, otherwise step the selected counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOTS; k++)
                ctr_q[k] <= CTR_INIT;
        end else if (up_en) begin
            ctr_q[up_pat] <= ctr_step(ctr_q[up_pat], up_seen);
        end
    end

    // Guess is the upper counter bit.
    assign rd_guess = ctr_q[rd_pat][CTR_W-1];

    // R4: a sharer below the top moves its counter up by one
    assert_ctr_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_seen && ctr_q[up_pat] != CTR_TOP)
        |=> ctr_q[$past(up_pat)] == ctr_t'($past(ctr_q[up_pat]) + ctr_t'(1)));

    // R4: a sharer at the top leaves the counter at the top
    assert_ctr_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_seen && ctr_q[up_pat] == CTR_TOP) |=> ctr_q[$past(up_pat)] == CTR_TOP);

    // R5: a non-sharer at the bottom leaves the counter at the bottom
    assert_ctr_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_seen && ctr_q[up_pat] == CTR_BOT) |=> ctr_q[$past(up_pat)] == CTR_BOT);

    // R10: counters not selected by the update pattern keep their value
    for (genvar k = 0; k < SLOTS; k++) begin : g_keep
        assert_ctr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(up_en && up_pat == DEPTH'(k)) |=> $stable(ctr_q[k]));
    end
endmodule

// File: rtl/cons_predictor.sv
`timescale 1ns/1ps
// Module: top of the per-consumer two-level sharer predictor. The history
// table supplies one pattern per processor. Each lane turns its pattern into
// a guess. The guesses are registered once, so a prediction follows its
// lookup by one clock.
// Assumes ENTRIES >= 2 and synchronous active-low reset.
module cons_predictor #(
    parameter int NPROC   = 4,
    parameter int DEPTH   = 2,
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lookup_valid,
    input  logic [$clog2(ENTRIES)-1:0] lookup_idx,
    input  logic                       update_valid,
    input  logic [$clog2(ENTRIES)-1:0] update_idx,
    input  logic [NPROC-1:0]           update_sharers,
    output logic                       pred_valid,
    output logic [NPROC-1:0]           pred_consumers
);
    localparam int ROW_W = NPROC * DEPTH;

    logic [ROW_W-1:0] rd_row;
    logic [ROW_W-1:0] up_row;
    logic [NPROC-1:0] guess;

    cpred_hist_table #(
        .NPROC  (NPROC),
        .DEPTH  (DEPTH),
        .ENTRIES(ENTRIES)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lookup_idx),
        .rd_pat (rd_row),
        .up_en  (update_valid),
        .up_idx (update_idx),
        .up_bits(update_sharers),
        .up_pat (up_row)
    );

    // One counter bank per processor, fed only by that processor's slice.
    for (genvar p = 0; p < NPROC; p++) begin : g_lane
        cpred_ctr_lane #(
            .DEPTH(DEPTH)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_pat  (rd_row[p*DEPTH +: DEPTH]),
            .rd_guess(guess[p]),
            .up_en   (update_valid),
            .up_pat  (up_row[p*DEPTH +: DEPTH]),
            .up_seen (update_sharers[p])
        );
    end

    // Register the guesses on a lookup and mark them valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid     <= 1'b0;
            pred_consumers <= '0;
        end else begin
            pred_valid <= lookup_valid;
            if (lookup_valid)
                pred_consumers <= guess;
        end
    end

    // R2: a lookup yields a valid prediction on the next cycle
    assert_look_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> pred_valid);

    // R2: no lookup, no valid prediction
    assert_idle_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !pred_valid);

    // R2: the vector holds when no lookup is presented
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> $stable(pred_consumers));
endmodule

// File: tb/cons_predictor_test.sv
`timescale 1ns/1ps
// Bench: walks a table of hand-worked vectors, then directed hold and reset
// cases. Inputs change on falling edges and results are read one falling
// edge later.
module cons_predictor_test;
    localparam int NPROC   = 4;
    localparam int DEPTH   = 2;
    localparam int ENTRIES = 8;
    localparam int ROWS    = 19;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lookup_valid;
    logic [2:0] lookup_idx;
    logic       update_valid;
    logic [2:0] update_idx;
    logic [3:0] update_sharers;
    logic       pred_valid;
    logic [3:0] pred_consumers;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cons_predictor #(
        .NPROC  (NPROC),
        .DEPTH  (DEPTH),
        .ENTRIES(ENTRIES)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lookup_valid  (lookup_valid),
        .lookup_idx    (lookup_idx),
        .update_valid  (update_valid),
        .update_idx    (update_idx),
        .update_sharers(update_sharers),
        .pred_valid    (pred_valid),
        .pred_consumers(pred_consumers)
    );

    // Row: {upd_v, upd_idx[3], sharers[4], look_v, look_idx[3], expect[4], req[4]}
    localparam logic [19:0] VEC [ROWS] = '{
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'd1 },  // R1 fresh entry
        {1'b1, 3'd0, 4'b0101, 1'b1, 3'd0, 4'b0000, 4'd9 },  // R9 same-edge old state
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd1, 4'b0101, 4'd8 },  // R8 bank shared by entry 1
        {1'b1, 3'd0, 4'b0101, 1'b1, 3'd0, 4'b0000, 4'd9 },  // R9 pattern 01 still weak
        {1'b1, 3'd0, 4'b0101, 1'b1, 3'd0, 4'b0000, 4'd6 },  // R6 pattern 11 weak
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd0, 4'b0101, 4'd4 },  // R4 counter 3 reached 2
        {1'b1, 3'd0, 4'b0101, 1'b0, 3'd0, 4'b0000, 4'd0 },
        {1'b1, 3'd0, 4'b0101, 1'b0, 3'd0, 4'b0000, 4'd0 },  // R4 saturate at 3
        {1'b1, 3'd0, 4'b0000, 1'b1, 3'd0, 4'b0101, 4'd4 },  // R4 no wrap past 3
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'd10},  // R10 counter 2 untouched
        {1'b1, 3'd0, 4'b0001, 1'b0, 3'd0, 4'b0000, 4'd0 },
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd0, 4'b0101, 4'd7 },  // R7 lanes diverge
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd1, 4'b0101, 4'd8 },  // R8 entry 1 still 00
        {1'b1, 3'd2, 4'b1010, 1'b0, 3'd0, 4'b0000, 4'd0 },
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd2, 4'b0000, 4'd5 },  // R5 counters 0 fell to 1
        {1'b1, 3'd2, 4'b1010, 1'b0, 3'd0, 4'b0000, 4'd0 },
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd2, 4'b0000, 4'd3 },  // R3 value 1 reads as 0
        {1'b1, 3'd2, 4'b1010, 1'b0, 3'd0, 4'b0000, 4'd0 },  // R5 saturate at 0
        {1'b0, 3'd0, 4'b0000, 1'b1, 3'd2, 4'b1010, 4'd7 }   // R7 odd lanes now consumers
    };

    // Compare one value and log a FAIL line on mismatch.
    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %b, expected %b", req, what, act, exp);
        end
    endtask

    // Drive a quiet cycle's inputs.
    task automatic idle();
        lookup_valid   = 1'b0;
        lookup_idx     = '0;
        update_valid   = 1'b0;
        update_idx     = '0;
        update_sharers = '0;
    endtask

    // Main sequence: reset, vector table, then directed cases.
    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        chk({3'b0, pred_valid}, 4'b0000, 2, "valid low in reset");   // R2
        chk(pred_consumers, 4'b0000, 1, "vector cleared in reset");   // R1
        rst_n = 1'b1;

        for (int i = 0; i < ROWS; i++) begin
            update_valid   = VEC[i][19];
            update_idx     = VEC[i][18:16];
            update_sharers = VEC[i][15:12];
            lookup_valid   = VEC[i][11];
            lookup_idx     = VEC[i][10:8];
            @(negedge clk);
            chk({3'b0, pred_valid}, {3'b0, VEC[i][11]}, 2, "valid follows lookup");  // R2
            if (VEC[i][11])
                chk(pred_consumers, VEC[i][7:4], int'(VEC[i][3:0]), $sformatf("table row %0d", i));
        end

        // R2: without a lookup the last vector stays put
        idle();
        @(negedge clk);
        chk(pred_consumers, 4'b1010, 2, "vector holds while idle");

        // R1: reset in mid-run returns every lane to weak-no
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(pred_consumers, 4'b0000, 1, "vector cleared by mid-run reset");
        rst_n        = 1'b1;
        lookup_valid = 1'b1;
        lookup_idx   = 3'd2;
        @(negedge clk);
        chk(pred_consumers, 4'b0000, 1, "entry 2 after reset");
        lookup_idx = 3'd0;
        @(negedge clk);
        chk(pred_consumers, 4'b0000, 1, "entry 0 after reset");
        idle();
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule